// File: doc/BRIEF.md
# Program Memory Checksum Calculator

This block forms the 16-bit verification checksum of a program memory image, so that a programmer can compare it with the value expected for a part. Program words are streamed in one per cycle with their address. The block keeps only the words that count for the selected device size and code-protect setting, and adds them into a running 16-bit sum.

A job opens with a one-cycle `start_i`. Words then arrive on `wr_valid_i`/`wr_addr_i`/`wr_data_i` in any order. A one-cycle `fin_i` closes the job. On that cycle the block takes the configuration word and the four ID bytes, folds them into the sum, and presents the result on `cksum_o` on the next cycle with a one-cycle `done_o`.

The last word of the part holds an oscillator calibration value and is never summed. Under code protection the summed window shrinks, and an ID term built from the low nibbles of the four ID bytes is added.

Top module: `prog_cksum`

## Requirements
- R1: Accepted program words (14 bits, zero-extended) are added modulo 2^16, and carries out of bit 15 are lost.
- R2: On `fin_i`, the configuration word `cfg_i` is ANDed with 0x3FFF before it is added.
- R3: With `cp_i` = 2'b11 (no protection), words at addresses 0 to size-2 are summed. The last address, size-1 (0x3FF for 1K, 0x7FF for 2K), holds the calibration word and is excluded.
- R4: With `size_2k_i` = 0 (1024 words), `cp_i` = 2'b01 or 2'b10 limits the sum to addresses 0x000 to 0x1FF.
- R5: With `size_2k_i` = 1 (2048 words), `cp_i` = 2'b10 limits the sum to 0x000 to 0x3FF and `cp_i` = 2'b01 limits it to 0x000 to 0x1FF. For either size, `cp_i` = 2'b00 sums no program words.
- R6: When `cp_i` is not 2'b11, an ID term is added on `fin_i`. ID k is `ids_i[8k+7:8k]`, and only its low nibble is kept. ID0 forms bits 15:12, ID1 bits 11:8, ID2 bits 7:4 and ID3 bits 3:0. IDs 0x12, 0x37, 0x04 and 0x26 give 0x2746.
- R7: A valid word whose address lies outside the window selected by R3 to R5, including any address at or above the part size, leaves the sum unchanged.
- R8: After a cycle with `fin_i` high, `done_o` is high for exactly one cycle and `cksum_o` holds the final sum until the next `fin_i`. A valid word on the `fin_i` cycle is included in that sum.
- R9: `start_i` discards the running sum. A valid word on the `start_i` cycle becomes the first term of the new sum.
- R10: After reset, `done_o` is 0 and `cksum_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a job and clears the running sum |
| size_2k_i | input | 1 | 1 = 2048-word part, 0 = 1024-word part |
| cp_i | input | 2 | Code-protect setting (11 off, 10/01 partial, 00 full) |
| wr_valid_i | input | 1 | Program word present |
| wr_addr_i | input | 11 | Word address |
| wr_data_i | input | 14 | Word value |
| fin_i | input | 1 | Closes the job; samples cfg_i and ids_i |
| cfg_i | input | 16 | Configuration word |
| ids_i | input | 32 | Four ID bytes, ID0 in bits 7:0 |
| cksum_o | output | 16 | Checksum of the last finished job |
| done_o | output | 1 | One-cycle pulse with a new checksum |

## Verification
The assertions take for granted that `size_2k_i` and `cp_i` stay constant from `start_i` to `fin_i`, and that `start_i` and `fin_i` never rise in the same cycle. The window and hold checks compare the running sum only across cycles where these settings apply. The stimulus changes size and protection only between jobs. It pulses `start_i` and `fin_i` in separate cycles, and streams every address of the 2K space, calibration and out-of-window words included. A behavioural model in the bench computes the expected sum, and the bench compares against it on every clock.

// File: rtl/prog_cksum_pkg.sv
package prog_cksum_pkg;
  localparam int ADDR_W = 11;
  localparam int DATA_W = 14;
  localparam int SUM_W  = 16;
  localparam int ID_W   = 8;
  localparam int ID_N   = 4;
  localparam int NIB_W  = SUM_W / ID_N;

  typedef enum logic [1:0] {
    CP_ALL  = 2'b00,
    CP_LOW  = 2'b01,
    CP_HIGH = 2'b10,
    CP_OFF  = 2'b11
  } cp_e;

  localparam logic [SUM_W-1:0] CFG_MASK = 16'h3FFF;
endpackage

// File: rtl/prog_cksum_window.sv
module prog_cksum_window
  import prog_cksum_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          size_2k_i,
  input  logic [1:0]    cp_i,
  input  logic          wr_valid_i,
  input  logic [AW-1:0] wr_addr_i,
  output logic          take_o
);
  localparam int FULL = 1 << AW;
  localparam int HALF = FULL / 2;
  localparam logic [AW-1:0] LIM_2K_OFF  = AW'(FULL - 2);
  localparam logic [AW-1:0] LIM_1K_OFF  = AW'(HALF - 2);
  localparam logic [AW-1:0] LIM_2K_HIGH = AW'(FULL / 2 - 1);
  localparam logic [AW-1:0] LIM_2K_LOW  = AW'(FULL / 4 - 1);
  localparam logic [AW-1:0] LIM_1K_PART = AW'(HALF / 2 - 1);

  logic [AW-1:0] lim;
  logic          any;

  always_comb begin
    any = 1'b1;
    lim = '0;
    unique case (cp_e'(cp_i))
      CP_OFF:  lim = size_2k_i ? LIM_2K_OFF  : LIM_1K_OFF;
      CP_HIGH: lim = size_2k_i ? LIM_2K_HIGH : LIM_1K_PART;
      CP_LOW:  lim = size_2k_i ? LIM_2K_LOW  : LIM_1K_PART;
      default: any = 1'b0;
    endcase
  end

  assign take_o = wr_valid_i && any && (wr_addr_i <= lim);
endmodule

// File: rtl/prog_cksum_idterm.sv
module prog_cksum_idterm
  import prog_cksum_pkg::*;
(
  input  logic [ID_N*ID_W-1:0] ids_i,
  output logic [SUM_W-1:0]     term_o
);
  // ID0 lands in the top nibble
  for (genvar k = 0; k < ID_N; k++) begin : g_nib
    assign term_o[SUM_W-1-k*NIB_W -: NIB_W] = ids_i[k*ID_W +: NIB_W];
  end
endmodule

// File: rtl/prog_cksum_acc.sv
module prog_cksum_acc
  import prog_cksum_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              take_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              fin_i,
  input  logic [SUM_W-1:0]  tail_i,
  output logic [SUM_W-1:0]  acc_o,
  output logic [SUM_W-1:0]  cksum_o,
  output logic              done_o
);
  logic [SUM_W-1:0] base, nxt;

  assign base = start_i ? '0 : acc_o;
  assign nxt  = base + (take_i ? SUM_W'(data_i) : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o   <= '0;
      cksum_o <= '0;
      done_o  <= 1'b0;
    end else begin
      acc_o  <= nxt;
      done_o <= fin_i;
      if (fin_i) cksum_o <= nxt + tail_i;
    end
  end
endmodule

// File: rtl/prog_cksum.sv
module prog_cksum
  import prog_cksum_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  size_2k_i,
  input  logic [1:0]            cp_i,
  input  logic                  wr_valid_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic                  fin_i,
  input  logic [SUM_W-1:0]      cfg_i,
  input  logic [ID_N*ID_W-1:0]  ids_i,
  output logic [SUM_W-1:0]      cksum_o,
  output logic                  done_o
);
  logic             take;
  logic [SUM_W-1:0] id_term, tail, acc_q;

  prog_cksum_window #(.AW(ADDR_W)) i_window (
    .size_2k_i (size_2k_i),
    .cp_i      (cp_i),
    .wr_valid_i(wr_valid_i),
    .wr_addr_i (wr_addr_i),
    .take_o    (take)
  );

  prog_cksum_idterm i_idterm (
    .ids_i (ids_i),
    .term_o(id_term)
  );

  assign tail = (cfg_i & CFG_MASK) + ((cp_e'(cp_i) == CP_OFF) ? '0 : id_term);

  prog_cksum_acc i_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .take_i (take),
    .data_i (wr_data_i),
    .fin_i  (fin_i),
    .tail_i (tail),
    .acc_o  (acc_q),
    .cksum_o(cksum_o),
    .done_o (done_o)
  );
endmodule

// File: rtl/prog_cksum_chk.sv
module prog_cksum_chk
  import prog_cksum_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              size_2k_i,
  input logic [1:0]        cp_i,
  input logic              wr_valid_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              fin_i,
  input logic [SUM_W-1:0]  acc_q,
  input logic [SUM_W-1:0]  cksum_o,
  input logic              done_o
);
  localparam int FULL = 1 << ADDR_W;
  logic [ADDR_W-1:0] cal_addr;
  assign cal_addr = size_2k_i ? ADDR_W'(FULL - 1) : ADDR_W'(FULL / 2 - 1);

  a_r8_done_after_fin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i |=> done_o);
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fin_i |=> !done_o);
  a_r8_cksum_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fin_i |=> $stable(cksum_o));
  a_r5_full_prot_no_words: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cp_i == 2'b00 && !start_i) |=> $stable(acc_q));
  a_r3_cal_excluded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_addr_i == cal_addr && !start_i) |=> $stable(acc_q));
  a_r9_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !wr_valid_i) |=> acc_q == '0);
endmodule

bind prog_cksum prog_cksum_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .size_2k_i (size_2k_i),
  .cp_i      (cp_i),
  .wr_valid_i(wr_valid_i),
  .wr_addr_i (wr_addr_i),
  .fin_i     (fin_i),
  .acc_q     (acc_q),
  .cksum_o   (cksum_o),
  .done_o    (done_o)
);

// File: tb/test_prog_cksum.sv
`timescale 1ns/1ps
module test_prog_cksum;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        size_2k_i = 1'b0;
  logic [1:0]  cp_i = 2'b11;
  logic        wr_valid_i = 1'b0;
  logic [10:0] wr_addr_i = '0;
  logic [13:0] wr_data_i = '0;
  logic        fin_i = 1'b0;
  logic [15:0] cfg_i = '0;
  logic [31:0] ids_i = '0;
  logic [15:0] cksum_o;
  logic        done_o;

  int n_vec = 0, n_bad = 0, cyc = 0;
  bit finished = 0;
  int exp_acc = 0, exp_ck = 0;
  bit exp_done = 0;

  always #2 clk_i = ~clk_i;

  prog_cksum i_prog_cksum (.*);

  function automatic int win_lim(bit s2k, bit [1:0] cp);
    int sz = s2k ? 2048 : 1024;
    case (cp)
      2'b11: return sz - 2;
      2'b10: return s2k ? 'h3FF : 'h1FF;
      2'b01: return 'h1FF;
      default: return -1;
    endcase
  endfunction

  function automatic int id_val(bit [31:0] ids);
    return ((ids[3:0]) << 12) | ((ids[11:8]) << 8) | ((ids[19:16]) << 4) | ids[27:24];
  endfunction

  // behavioural reference, updated on each edge
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_acc = 0; exp_ck = 0; exp_done = 0;
    end else begin
      int b, t;
      b = start_i ? 0 : exp_acc;
      if (wr_valid_i && int'(wr_addr_i) <= win_lim(size_2k_i, cp_i)) b = b + int'(wr_data_i);
      b = b % 65536;
      exp_done = fin_i;
      if (fin_i) begin
        t = b + (cfg_i & 'h3FFF) + ((cp_i != 2'b11) ? id_val(ids_i) : 0);
        exp_ck = t % 65536;
      end
      exp_acc = b;
    end
  end

  always @(negedge clk_i) if (rst_ni && !finished) begin
    cyc++;
    n_vec++;
    if (done_o !== exp_done || int'(cksum_o) != exp_ck) begin
      n_bad++;
      $display("FAIL R8/R1 model cyc %0d: done=%0b cksum=%h expected done=%0b cksum=%h",
               cyc, done_o, cksum_o, exp_done, exp_ck[15:0]);
    end
  end

  task automatic check(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk_i); endtask

  task automatic begin_job(bit s2k, bit [1:0] cp);
    size_2k_i = s2k; cp_i = cp; start_i = 1'b1; tick(); start_i = 1'b0;
  endtask

  task automatic put(int a, int d);
    wr_valid_i = 1'b1; wr_addr_i = 11'(a); wr_data_i = 14'(d); tick(); wr_valid_i = 1'b0;
  endtask

  task automatic end_job(int cfg, bit [31:0] ids);
    cfg_i = 16'(cfg); ids_i = ids; fin_i = 1'b1; tick(); fin_i = 1'b0;
  endtask

  task automatic sweep(bit s2k, bit [1:0] cp, int seed);
    begin_job(s2k, cp);
    for (int a = 0; a < 2048; a++) put(a, (a * seed + 'h1234) & 'h3FFF);
    end_job('hC5A7, 32'h9F_A3_5B_E1);
  endtask

  initial begin
    repeat (3) tick();
    check("R10 reset done", int'(done_o), 0);
    check("R10 reset cksum", int'(cksum_o), 0);
    rst_ni = 1'b1; tick();

    // R6 documented packing example, full protection so no words count
    begin_job(1'b0, 2'b00);
    put(5, 'h123);
    end_job(0, {8'h26, 8'h04, 8'h37, 8'h12});
    check("R6 id example", int'(cksum_o), 'h2746);
    check("R8 done pulse", int'(done_o), 1);
    tick();
    check("R8 done single", int'(done_o), 0);
    check("R8 cksum held", int'(cksum_o), 'h2746);

    // R3 calibration word excluded, R2 config mask
    begin_job(1'b0, 2'b11);
    put('h3FF, 'h3FFF);
    put('h3FE, 5);
    end_job('hFFFF, 32'hFFFF_FFFF);
    check("R3 R2 cal excluded", int'(cksum_o), 'h4004);

    // R7 addresses above 1K part ignored
    begin_job(1'b0, 2'b11);
    put('h400, 'h111);
    put('h7FE, 'h222);
    put(1, 7);
    end_job(0, 0);
    check("R7 out of range", int'(cksum_o), 7);

    // R1 wraparound
    begin_job(1'b1, 2'b11);
    for (int a = 0; a < 8; a++) put(a, 'h3FFF);
    end_job(0, 0);
    check("R1 wrap", int'(cksum_o), (8 * 'h3FFF) % 65536);

    // R4 1K partial window boundary
    begin_job(1'b0, 2'b10);
    put('h1FF, 10);
    put('h200, 20);
    end_job(0, 0);
    check("R4 1K window", int'(cksum_o), 10);

    // R5 2K windows
    begin_job(1'b1, 2'b10);
    put('h3FF, 3);
    put('h400, 4);
    end_job(0, 0);
    check("R5 2K cp10", int'(cksum_o), 3);
    begin_job(1'b1, 2'b01);
    put('h1FF, 3);
    put('h200, 4);
    end_job(0, 0);
    check("R5 2K cp01", int'(cksum_o), 3);

    // R9 start clears, word on start cycle counts; R8 word on fin counts
    begin_job(1'b1, 2'b11);
    put(2, 100);
    size_2k_i = 1'b1; cp_i = 2'b11;
    start_i = 1'b1; wr_valid_i = 1'b1; wr_addr_i = 11'd3; wr_data_i = 14'd9; tick();
    start_i = 1'b0;
    wr_addr_i = 11'd4; wr_data_i = 14'd1; cfg_i = 0; fin_i = 1'b1; tick();
    fin_i = 1'b0; wr_valid_i = 1'b0;
    check("R9 R8 start/fin words", int'(cksum_o), 10);

    // full sweeps against the model for every size and setting
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < 4; c++) sweep(s[0], 2'(c), 37 + 11 * c + s);
    tick();

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #600000;
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule